// File: doc/BRIEF.md
# Packet Output FIFO with Selectable Back-Pressure

This block buffers the data words produced by an acquisition sequencer until a bus master reads them out. A sequencer pushes words through a valid/ready write port; the bus side pops them one at a time through a valid/ready read port whose data appears in the cycle after the pop is accepted. The storage is 512 words of 16 bits by default. Both sizes are parameters.

The block also decides when the module must refuse new triggers. It has two back-pressure modes, chosen by single-cycle command pulses. In the cautious mode, busy is raised as soon as more than half the storage is occupied, so a whole packet always fits. In the greedy mode, busy is raised only when the storage is completely full. This uses every location, but the last words of a sequence can be lost. Three active-low status bits (half, full, empty) and the current mode bit are provided for a neighbouring control register to present.

Write-side rules: `wr_ready` is low only while the FIFO is full. A word offered with `wr_valid` high while `wr_ready` is low is discarded, not held, and it sets a sticky overflow flag. Read-side rules: `rd_valid` is high whenever at least one word is stored. A read strobe given while `rd_valid` is low is ignored and the read data is left unchanged.

Top module: `pkt_out_fifo`

## Requirements
- R1: Words leave the read port in the order they were accepted at the write port, with their 16-bit values unchanged, and up to DEPTH (512) words can be held at once.
- R2: A read is accepted on a clock edge where `rd_ready` and `rd_valid` are both high. The oldest word then appears on `rd_data` after that edge and stays there until the next accepted read. `rd_valid` is high exactly when the FIFO holds at least one word.
- R3: A read strobe while the FIFO is empty moves nothing, and `rd_data` keeps the last word read.
- R4: A write is accepted on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low only while the FIFO holds DEPTH words.
- R5: A write offered while the FIFO is full is dropped and sets `overflow`. `overflow` stays set until reset.
- R6: A read and a write accepted on the same edge leave the occupancy unchanged, and both words are handled correctly.
- R7: `flags_n` is active-low. Bit 0 is 0 when occupancy exceeds DEPTH/2, bit 1 is 0 when the FIFO is full, and bit 2 is 0 when it is empty. A neighbour maps these to register bits 12, 13 and 14.
- R8: In half mode (`mode_full` = 0), `busy` is 1 exactly when occupancy exceeds DEPTH/2.
- R9: In full mode (`mode_full` = 1), `busy` is 1 exactly when the FIFO is full.
- R10: A pulse on `sel_half` selects half mode and a pulse on `sel_full` selects full mode, from the next cycle on. If both pulse together, half mode wins. `mode_full` reads 0 for half mode and 1 for full mode.
- R11: Reset (`rst_n` low) empties the FIFO, selects half mode, clears `overflow` and sets `rd_data` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Sequencer offers a word |
| wr_ready | output | 1 | FIFO can take a word |
| wr_data | input | 16 | Word to store |
| rd_ready | input | 1 | Bus read strobe |
| rd_valid | output | 1 | At least one word stored |
| rd_data | output | 16 | Last word popped |
| sel_half | input | 1 | Pulse: choose half-threshold back-pressure |
| sel_full | input | 1 | Pulse: choose full-threshold back-pressure |
| mode_full | output | 1 | Current mode, 1 = full mode |
| busy | output | 1 | Refuse new triggers |
| flags_n | output | 3 | Active-low {empty, full, half} |
| overflow | output | 1 | Sticky: a write was dropped |

## Verification
The hardest condition to reach is an occupancy held exactly at the half boundary or at the full boundary while reads and writes collide. Counting errors there show up only as a busy or flag edge that comes one word too early or too late. The stimulus fills the storage to the threshold with single pushes and then runs a stretch of simultaneous push-and-pop cycles. A single extra push or pop afterwards must then move `busy` and the half flag across the boundary in exactly that cycle. The full case is reached by switching to full mode and pushing all 512 words, followed by one extra word that must vanish without trace in the full drain.

// File: rtl/pkt_fifo_pkg.sv
package pkt_fifo_pkg;
  typedef enum logic {
    BP_HALF = 1'b0,
    BP_FULL = 1'b1
  } bp_mode_e;

  localparam int FLAG_HALF  = 0;
  localparam int FLAG_FULL  = 1;
  localparam int FLAG_EMPTY = 2;
endpackage

// File: rtl/pkt_fifo_store.sv
module pkt_fifo_store #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // output register only moves on an accepted pop
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pkt_fifo_ctr.sv
module pkt_fifo_ctr #(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic          rd_req,
  output logic          wr_fire,
  output logic          rd_fire,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [CW-1:0] occ,
  output logic          full,
  output logic          empty,
  output logic          ovf
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_C  = AW'(DEPTH - 1);

  assign full    = (occ == DEPTH_C);
  assign empty   = (occ == '0);
  assign wr_fire = wr_req && !full;
  assign rd_fire = rd_req && !empty;

  logic [AW-1:0] wptr_nx, rptr_nx;

  generate
    if ((1 << AW) == DEPTH) begin : g_pow2
      assign wptr_nx = wptr + 1'b1;
      assign rptr_nx = rptr + 1'b1;
    end else begin : g_wrap
      assign wptr_nx = (wptr == LAST_C) ? '0 : wptr + 1'b1;
      assign rptr_nx = (rptr == LAST_C) ? '0 : rptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      occ  <= '0;
      ovf  <= 1'b0;
    end else begin
      if (wr_fire) wptr <= wptr_nx;
      if (rd_fire) rptr <= rptr_nx;
      case ({wr_fire, rd_fire})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
      if (wr_req && full) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/pkt_fifo_bp.sv
module pkt_fifo_bp
  import pkt_fifo_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_half,
  input  logic          sel_full,
  input  logic [CW-1:0] occ,
  input  logic          full,
  input  logic          empty,
  output bp_mode_e      mode,
  output logic          busy,
  output logic [2:0]    flags_n
);
  localparam logic [CW-1:0] HALF_C = CW'(DEPTH / 2);

  logic over_half;
  assign over_half = (occ > HALF_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mode <= BP_HALF;
    else if (sel_half) mode <= BP_HALF;
    else if (sel_full) mode <= BP_FULL;
  end

  always_comb begin
    busy = (mode == BP_FULL) ? full : over_half;
    flags_n = '1;
    flags_n[FLAG_HALF]  = !over_half;
    flags_n[FLAG_FULL]  = !full;
    flags_n[FLAG_EMPTY] = !empty;
  end
endmodule

// File: rtl/pkt_out_fifo.sv
module pkt_out_fifo
  import pkt_fifo_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DEPTH = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_ready,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data,
  input  logic             sel_half,
  input  logic             sel_full,
  output logic             mode_full,
  output logic             busy,
  output logic [2:0]       flags_n,
  output logic             overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH) + 1;

  logic          wr_fire, rd_fire, full, empty;
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] occ;
  bp_mode_e      mode;

  pkt_fifo_ctr #(.DEPTH(DEPTH)) u_ctr (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_valid), .rd_req(rd_ready),
    .wr_fire(wr_fire), .rd_fire(rd_fire), .wptr(wptr), .rptr(rptr),
    .occ(occ), .full(full), .empty(empty), .ovf(overflow)
  );

  pkt_fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .we(wr_fire), .waddr(wptr), .wdata(wr_data),
    .re(rd_fire), .raddr(rptr), .rdata(rd_data)
  );

  pkt_fifo_bp #(.DEPTH(DEPTH)) u_bp (
    .clk(clk), .rst_n(rst_n), .sel_half(sel_half), .sel_full(sel_full),
    .occ(occ), .full(full), .empty(empty), .mode(mode), .busy(busy),
    .flags_n(flags_n)
  );

  assign wr_ready  = !full;
  assign rd_valid  = !empty;
  assign mode_full = (mode == BP_FULL);
endmodule

// File: rtl/pkt_out_fifo_chk.sv
module pkt_out_fifo_chk #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 512,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             rd_ready,
  input logic             rd_valid,
  input logic [WIDTH-1:0] rd_data,
  input logic             sel_half,
  input logic             sel_full,
  input logic             mode_full,
  input logic             busy,
  input logic [2:0]       flags_n,
  input logic             overflow,
  input logic [CW-1:0]    occ
);
  assert_ready_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_n[1] == 1'b0) |-> !wr_ready);
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> overflow);
  assert_sticky_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  assert_empty_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ready && !rd_valid) |=> $stable(rd_data));
  assert_simul_occ_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && rd_ready && rd_valid) |=> $stable(occ));
  assert_occ_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));
  assert_half_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_full && occ > CW'(DEPTH / 2)) |-> busy);
  assert_full_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_full && flags_n[1]) |-> !busy);
  assert_mode_sel_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_full && !sel_half) |=> mode_full);
  assert_mode_half_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sel_half |=> !mode_full);
endmodule

bind pkt_out_fifo pkt_out_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
  .sel_half(sel_half), .sel_full(sel_full), .mode_full(mode_full),
  .busy(busy), .flags_n(flags_n), .overflow(overflow), .occ(occ)
);

// File: tb/pkt_out_fifo_bench.sv
`timescale 1ns/1ps
module pkt_out_fifo_bench;
  localparam int W = 16;
  localparam int D = 512;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_valid = 1'b0, rd_ready = 1'b0, sel_half = 1'b0, sel_full = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         wr_ready, rd_valid, mode_full, busy, overflow;
  logic [W-1:0] rd_data;
  logic [2:0]   flags_n;

  int checks = 0;
  int errors = 0;
  int q[$];
  int seed_v = 16'h1357;

  always #2 clk = ~clk;

  pkt_out_fifo #(.WIDTH(W), .DEPTH(D)) u_pkt_out_fifo (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .sel_half(sel_half), .sel_full(sel_full),
    .mode_full(mode_full), .busy(busy), .flags_n(flags_n), .overflow(overflow)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int next_word();
    seed_v = (seed_v * 37 + 11) & 16'hFFFF;
    return seed_v;
  endfunction

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    q.delete();
  endtask

  task automatic push(input int v);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = W'(v);
    @(posedge clk); #1;
    wr_valid = 1'b0;
    if (q.size() < D) q.push_back(v);
  endtask

  // pop and check data against the model
  task automatic pop(input string req);
    int exp;
    @(negedge clk); rd_ready = 1'b1;
    @(posedge clk); #1; rd_ready = 1'b0;
    if (q.size() > 0) begin
      exp = q.pop_front();
      check(int'(rd_data) == exp, req, int'(rd_data), exp);
    end
  endtask

  task automatic push_pop(input int v);
    int exp;
    @(negedge clk);
    wr_valid = 1'b1; wr_data = W'(v); rd_ready = 1'b1;
    @(posedge clk); #1;
    wr_valid = 1'b0; rd_ready = 1'b0;
    exp = q.pop_front();
    q.push_back(v);
    check(int'(rd_data) == exp, "R6 data", int'(rd_data), exp);
  endtask

  task automatic pulse(input bit half, input bit full);
    @(negedge clk); sel_half = half; sel_full = full;
    @(negedge clk); sel_half = 1'b0; sel_full = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    #1;
    check(flags_n == 3'b011, "R11/R7 flags after reset", flags_n, 3'b011);
    check(!rd_valid && wr_ready, "R11 empty after reset", {rd_valid, wr_ready}, 2'b01);
    check(!mode_full && !busy && !overflow, "R11 mode/busy/ovf", {mode_full, busy, overflow}, 0);
    check(rd_data == '0, "R11 rd_data zero", rd_data, 0);
  endtask

  task automatic t_order();
    do_reset();
    for (int i = 0; i < 20; i++) push(next_word());
    check(rd_valid && flags_n[2], "R2 valid when stored", rd_valid, 1);
    for (int i = 0; i < 20; i++) pop("R1 order");
    check(!rd_valid && !flags_n[2], "R7 empty flag low", flags_n, 3'b011);
  endtask

  task automatic t_empty_read();
    do_reset();
    push(16'hA5C3);
    pop("R2 single");
    @(negedge clk); rd_ready = 1'b1;
    @(posedge clk); #1; rd_ready = 1'b0;
    check(rd_data == 16'hA5C3, "R3 hold on empty read", rd_data, 16'hA5C3);
    push(16'h0F0F);
    pop("R3 pointer unmoved");
  endtask

  task automatic t_half_mode();
    do_reset();
    for (int i = 0; i < D / 2; i++) push(next_word());
    check(!busy && flags_n[0], "R8 not busy at half", {busy, flags_n[0]}, 1);
    push(next_word());
    check(busy && !flags_n[0], "R8/R7 busy above half", {busy, flags_n[0]}, 2);
    for (int i = 0; i < 12; i++) push_pop(next_word());
    check(busy, "R6 occupancy held across simultaneous ops", busy, 1);
    pop("R1 drain");
    check(!busy && flags_n[0], "R6/R8 busy drops after one pop", {busy, flags_n[0]}, 1);
    while (q.size() > 0) pop("R1 drain");
  endtask

  task automatic t_full_mode();
    int exp;
    do_reset();
    pulse(1'b0, 1'b1);
    check(mode_full, "R10 full mode selected", mode_full, 1);
    for (int i = 0; i < D / 2 + 40; i++) push(next_word());
    check(!busy && !flags_n[0], "R9 no busy above half", {busy, flags_n[0]}, 0);
    while (q.size() < D) push(next_word());
    check(busy && !flags_n[1] && !wr_ready, "R9/R4 busy when full",
          {busy, flags_n[1], wr_ready}, 4);
    check(!overflow, "R5 no overflow yet", overflow, 0);
    push(16'hDEAD);
    check(overflow, "R5 overflow set", overflow, 1);
    pop("R5 first word intact");
    check(!busy && wr_ready, "R9 busy clears below full", {busy, wr_ready}, 1);
    while (q.size() > 0) pop("R5 no dropped word stored");
    check(overflow, "R5 overflow sticky", overflow, 1);
    exp = 0;
    check(!rd_valid, "R2 empty after drain", rd_valid, exp);
  endtask

  task automatic t_mode_select();
    do_reset();
    pulse(1'b0, 1'b1);
    check(mode_full, "R10 mode bit 1", mode_full, 1);
    pulse(1'b1, 1'b1);
    check(!mode_full, "R10 half wins tie", mode_full, 0);
    pulse(1'b0, 1'b1);
    do_reset();
    #1;
    check(!mode_full, "R11 reset selects half", mode_full, 0);
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_order();
        t_empty_read();
        t_half_mode();
        t_full_mode();
        t_mode_select();
      end
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule